// File: doc/BRIEF.md
# Domain-Tagged Peripheral Access Checker

The block gives every bus master a security domain tag and decides, for each
peripheral access, whether the tag of the requesting master permits it. Software
writes one assignment word per master (its domain and a lock) and one permission
word per peripheral (a two-bit policy for each of four domains, a semaphore
requirement and a lock) through a simple register port. The access-check port takes a
master index, a peripheral index and a direction, and it answers grant or deny in the
same cycle, together with the domain that the master resolved to.

A lock bit freezes a word until the next reset. When a peripheral is marked as
requiring a semaphore, an access to it is granted only while an external
gate-held input reports that the requester owns that peripheral's gate. Indices
beyond the configured master or peripheral count are always denied. Writes to them
are dropped and reads of them return zero. A status word returns the domain of the
master that performs the current register access.

Top module: `dpg_top`

## Requirements
- R1: A master assignment word carries the domain in bits [1:0] and the lock in bit 31. Every other bit reads as zero whatever was written.
- R2: After reset, every master word reads 0 (domain 0, unlocked). Every peripheral word reads 0x000000FF, which gives read and write to all four domains with the semaphore requirement clear and the word unlocked.
- R3: Once a master word's lock bit is 1, later writes to that word have no effect until reset. Its domain and its lock both stay as they were.
- R4: A peripheral word holds domain d's policy at bits [2d+1:2d], with 0 = no access, 1 = write only, 2 = read only, 3 = read and write. A write access needs policy bit 0 set and a read access needs policy bit 1 set.
- R5: Once a peripheral word's lock bit (bit 31) is 1, later writes to that word have no effect until reset. This covers its policies, its semaphore flag and its lock.
- R6: When a peripheral's semaphore flag (bit 30) is 1, an access that its policy allows is granted only if accSemHeld is 1. Otherwise the access is denied.
- R7: accGrant and accDeny depend combinationally on the inputs in the same cycle. Exactly one of them is 1 while accValid is 1, and both are 0 otherwise. accDomain gives the domain of accMaster.
- R8: regAddr bits [5:4] select the bank: 0 = master words, 1 = peripheral words, 2 = status. Bits [3:0] give the index. The status word returns the domain of regMaster in bits [1:0], with all other bits zero.
- R9: A master index of NUM_MASTERS or above, or a peripheral index of NUM_PERIPHS or above, is always denied and resolves to domain 0. Writes to such an index are ignored and reads of it return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 6 | Bank select [5:4] and index [3:0] |
| regWData | input | 32 | Register write data |
| regMaster | input | 4 | Master issuing the register access |
| regRdData | output | 32 | Combinational read data for regAddr |
| accValid | input | 1 | Access check request |
| accMaster | input | 4 | Requesting master index |
| accPeriph | input | 4 | Target peripheral index |
| accWrite | input | 1 | 1 = write access, 0 = read access |
| accSemHeld | input | 1 | Requester holds the target's semaphore gate |
| accGrant | output | 1 | Access permitted |
| accDeny | output | 1 | Access refused |
| accDomain | output | 2 | Domain the requesting master resolved to |

## Verification
The bench writes to locked master and peripheral words and then reads them back and
checks accesses. A design with a weak lock would report the new domain or policy, or
grant an access that the frozen word refuses. It sets the semaphore flag and toggles
the gate input, which exposes a design that ignores the flag or that lets the gate
bypass a no-access policy. It sends out-of-range master and peripheral indices to both
ports. A design that aliases them onto real entries would grant these accesses, change
a real word, or return non-zero data. Random traffic with single-direction policies
catches a swap of the read and write policy bits and a wrong domain field offset.

// File: rtl/dpg_pkg.sv
package dpg_pkg;
  localparam int unsigned IDX_W    = 4;
  localparam int unsigned DOM_W    = 2;
  localparam int unsigned NUM_DOM  = 4;
  localparam int unsigned POL_W    = DOM_W * NUM_DOM;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned LOCK_BIT = 31;
  localparam int unsigned SEM_BIT  = 30;

  typedef enum logic [1:0] {
    BANK_MASTER = 2'd0,
    BANK_PERIPH = 2'd1,
    BANK_STATUS = 2'd2,
    BANK_NONE   = 2'd3
  } bank_e;

  typedef struct packed {
    logic             wrMaster;
    logic             wrPeriph;
    bank_e            rdBank;
    logic [IDX_W-1:0] idx;
  } strobe_t;
endpackage

// File: rtl/dpg_ctrl.sv
module dpg_ctrl
  import dpg_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned NUM_PERIPHS = 10
) (
  input  logic             regWrEn,
  input  logic [IDX_W+1:0] regAddr,
  output strobe_t          strb
);
  localparam logic [IDX_W-1:0] M_LIM = IDX_W'(NUM_MASTERS);
  localparam logic [IDX_W-1:0] P_LIM = IDX_W'(NUM_PERIPHS);

  bank_e            bank;
  logic [IDX_W-1:0] idx;
  logic             idxOk;

  always_comb begin
    bank = bank_e'(regAddr[IDX_W+1:IDX_W]);
    idx  = regAddr[IDX_W-1:0];
    unique case (bank)
      BANK_MASTER: idxOk = idx < M_LIM;
      BANK_PERIPH: idxOk = idx < P_LIM;
      BANK_STATUS: idxOk = 1'b1;
      default:     idxOk = 1'b0;
    endcase
    strb.idx      = idx;
    strb.wrMaster = regWrEn && idxOk && (bank == BANK_MASTER);
    strb.wrPeriph = regWrEn && idxOk && (bank == BANK_PERIPH);
    strb.rdBank   = idxOk ? bank : BANK_NONE;
  end
endmodule

// File: rtl/dpg_datapath.sv
module dpg_datapath
  import dpg_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned NUM_PERIPHS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [WORD_W-1:0] regWData,
  input  logic [IDX_W-1:0]  regMaster,
  output logic [WORD_W-1:0] regRdData,
  input  logic              accValid,
  input  logic [IDX_W-1:0]  accMaster,
  input  logic [IDX_W-1:0]  accPeriph,
  input  logic              accWrite,
  input  logic              accSemHeld,
  output logic              accGrant,
  output logic              accDeny,
  output logic [DOM_W-1:0]  accDomain
);
  localparam int unsigned MW = $clog2(NUM_MASTERS);
  localparam int unsigned PW = $clog2(NUM_PERIPHS);
  localparam logic [IDX_W-1:0] M_LIM = IDX_W'(NUM_MASTERS);
  localparam logic [IDX_W-1:0] P_LIM = IDX_W'(NUM_PERIPHS);

  logic [NUM_MASTERS-1:0][DOM_W-1:0] mDom;
  logic [NUM_MASTERS-1:0]            mLock;
  logic [NUM_PERIPHS-1:0][POL_W-1:0] pPol;
  logic [NUM_PERIPHS-1:0]            pSem;
  logic [NUM_PERIPHS-1:0]            pLock;

  logic unusedWData;
  assign unusedWData = ^regWData[SEM_BIT-1:POL_W];

  // configuration storage; a locked entry accepts nothing until reset
  always_ff @(posedge clk) begin
    if (!rstN) begin
      mDom  <= '0;
      mLock <= '0;
      pPol  <= {NUM_PERIPHS{{POL_W{1'b1}}}};
      pSem  <= '0;
      pLock <= '0;
    end else begin
      for (int m = 0; m < NUM_MASTERS; m++) begin
        if (strb.wrMaster && strb.idx == IDX_W'(m) && !mLock[m]) begin
          mDom[m]  <= regWData[DOM_W-1:0];
          mLock[m] <= regWData[LOCK_BIT];
        end
      end
      for (int p = 0; p < NUM_PERIPHS; p++) begin
        if (strb.wrPeriph && strb.idx == IDX_W'(p) && !pLock[p]) begin
          pPol[p]  <= regWData[POL_W-1:0];
          pSem[p]  <= regWData[SEM_BIT];
          pLock[p] <= regWData[LOCK_BIT];
        end
      end
    end
  end

  // register read mux
  logic [MW-1:0] rdMIdx;
  logic [PW-1:0] rdPIdx;
  logic          regMOk;
  logic [DOM_W-1:0] regMDom;

  always_comb begin
    rdMIdx  = strb.idx[MW-1:0];
    rdPIdx  = strb.idx[PW-1:0];
    regMOk  = regMaster < M_LIM;
    regMDom = regMOk ? mDom[regMaster[MW-1:0]] : '0;
    regRdData = '0;
    unique case (strb.rdBank)
      BANK_MASTER: begin
        regRdData[LOCK_BIT]    = mLock[rdMIdx];
        regRdData[DOM_W-1:0]   = mDom[rdMIdx];
      end
      BANK_PERIPH: begin
        regRdData[LOCK_BIT]    = pLock[rdPIdx];
        regRdData[SEM_BIT]     = pSem[rdPIdx];
        regRdData[POL_W-1:0]   = pPol[rdPIdx];
      end
      BANK_STATUS: regRdData[DOM_W-1:0] = regMDom;
      default:     regRdData = '0;
    endcase
  end

  // access check: combinational from registered configuration
  logic             mOk, pOk, polOk, semOk;
  logic [PW-1:0]    aPIdx;
  logic [DOM_W-1:0] aDom;
  logic [DOM_W-1:0] field;

  always_comb begin
    mOk   = accMaster < M_LIM;
    pOk   = accPeriph < P_LIM;
    aPIdx = accPeriph[PW-1:0];
    aDom  = mOk ? mDom[accMaster[MW-1:0]] : '0;
    field = pOk ? pPol[aPIdx][DOM_W*aDom +: DOM_W] : '0;
    polOk = accWrite ? field[0] : field[1];
    semOk = pOk && (!pSem[aPIdx] || accSemHeld);
    accGrant  = accValid && mOk && pOk && polOk && semOk;
    accDeny   = accValid && !accGrant;
    accDomain = aDom;
  end

  // assertions next to the storage they guard
  for (genvar m = 0; m < NUM_MASTERS; m++) begin : g_mchk
    assert_mlock_hold_R3: assert property (@(posedge clk) disable iff (!rstN)
      mLock[m] |=> (mLock[m] && $stable(mDom[m])));
  end
  for (genvar p = 0; p < NUM_PERIPHS; p++) begin : g_pchk
    assert_plock_hold_R5: assert property (@(posedge clk) disable iff (!rstN)
      pLock[p] |=> (pLock[p] && $stable(pPol[p]) && $stable(pSem[p])));
  end

  assert_grant_deny_excl_R7: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> (accGrant != accDeny));
  assert_idle_quiet_R7: assert property (@(posedge clk) disable iff (!rstN)
    !accValid |-> (!accGrant && !accDeny));
  assert_oob_deny_R9: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && (accMaster >= M_LIM || accPeriph >= P_LIM)) |-> (accDeny && accDomain == '0));
  assert_sem_gate_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accGrant && !accSemHeld) |-> !pSem[aPIdx]);
endmodule

// File: rtl/dpg_top.sv
module dpg_top
  import dpg_pkg::*;
#(
  parameter int unsigned NUM_MASTERS = 6,
  parameter int unsigned NUM_PERIPHS = 10
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [IDX_W+1:0]  regAddr,
  input  logic [WORD_W-1:0] regWData,
  input  logic [IDX_W-1:0]  regMaster,
  output logic [WORD_W-1:0] regRdData,
  input  logic              accValid,
  input  logic [IDX_W-1:0]  accMaster,
  input  logic [IDX_W-1:0]  accPeriph,
  input  logic              accWrite,
  input  logic              accSemHeld,
  output logic              accGrant,
  output logic              accDeny,
  output logic [DOM_W-1:0]  accDomain
);
  strobe_t strb;

  dpg_ctrl #(.NUM_MASTERS(NUM_MASTERS), .NUM_PERIPHS(NUM_PERIPHS)) i_ctrl (
    .regWrEn(regWrEn), .regAddr(regAddr), .strb(strb)
  );

  dpg_datapath #(.NUM_MASTERS(NUM_MASTERS), .NUM_PERIPHS(NUM_PERIPHS)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .regWData(regWData),
    .regMaster(regMaster), .regRdData(regRdData),
    .accValid(accValid), .accMaster(accMaster), .accPeriph(accPeriph),
    .accWrite(accWrite), .accSemHeld(accSemHeld),
    .accGrant(accGrant), .accDeny(accDeny), .accDomain(accDomain)
  );
endmodule

// File: tb/test_dpg_top.sv
module test_dpg_top;
  localparam int NM = 6;
  localparam int NP = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [5:0]  regAddr = '0;
  logic [31:0] regWData = '0;
  logic [3:0]  regMaster = '0;
  logic [31:0] regRdData;
  logic        accValid = 1'b0;
  logic [3:0]  accMaster = '0;
  logic [3:0]  accPeriph = '0;
  logic        accWrite = 1'b0;
  logic        accSemHeld = 1'b0;
  logic        accGrant, accDeny;
  logic [1:0]  accDomain;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // bench model of the configuration
  logic [1:0] mDomM [16];
  logic       mLockM [16];
  logic [7:0] pPolM [16];
  logic       pSemM [16];
  logic       pLockM [16];

  always #4 clk = ~clk;

  dpg_top i_dpg_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWData(regWData), .regMaster(regMaster), .regRdData(regRdData),
    .accValid(accValid), .accMaster(accMaster), .accPeriph(accPeriph),
    .accWrite(accWrite), .accSemHeld(accSemHeld),
    .accGrant(accGrant), .accDeny(accDeny), .accDomain(accDomain)
  );

  function automatic logic [1:0] domOf(logic [3:0] m);
    return (m < NM) ? mDomM[m] : 2'd0;
  endfunction

  function automatic logic [31:0] expRead(logic [5:0] a, logic [3:0] rm);
    logic [3:0] i = a[3:0];
    case (a[5:4])
      2'd0: return (i < NM) ? {mLockM[i], 29'd0, mDomM[i]} : 32'd0;
      2'd1: return (i < NP) ? {pLockM[i], pSemM[i], 22'd0, pPolM[i]} : 32'd0;
      2'd2: return {30'd0, domOf(rm)};
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic expGrant(logic v, logic [3:0] m, logic [3:0] p, logic w, logic sh);
    logic [1:0] f;
    if (!v || m >= NM || p >= NP) return 1'b0;
    f = pPolM[p][2*domOf(m) +: 2];
    if (!(w ? f[0] : f[1])) return 1'b0;
    if (pSemM[p] && !sh) return 1'b0;
    return 1'b1;
  endfunction

  task automatic modelWrite(logic [5:0] a, logic [31:0] d);
    logic [3:0] i = a[3:0];
    if (a[5:4] == 2'd0 && i < NM && !mLockM[i]) begin
      mDomM[i] = d[1:0]; mLockM[i] = d[31];
    end else if (a[5:4] == 2'd1 && i < NP && !pLockM[i]) begin
      pPolM[i] = d[7:0]; pSemM[i] = d[30]; pLockM[i] = d[31];
    end
  endtask

  task automatic check(string req, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic doWrite(logic [5:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWData = d;
    @(negedge clk);
    regWrEn = 1'b0;
    modelWrite(a, d);
  endtask

  task automatic doRead(string req, logic [5:0] a, logic [3:0] rm);
    @(negedge clk);
    regAddr = a; regMaster = rm;
    #1 check(req, regRdData, expRead(a, rm));
  endtask

  task automatic doAcc(string req, logic [3:0] m, logic [3:0] p, logic w, logic sh);
    @(negedge clk);
    accValid = 1'b1; accMaster = m; accPeriph = p; accWrite = w; accSemHeld = sh;
    #1;
    check(req, {29'd0, accGrant, accDeny, 1'b0},
          {29'd0, expGrant(1'b1, m, p, w, sh), !expGrant(1'b1, m, p, w, sh), 1'b0});
    check(req, {30'd0, accDomain}, {30'd0, domOf(m)});
    accValid = 1'b0;
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h1F2E3D4C));
    for (int i = 0; i < 16; i++) begin
      mDomM[i] = 0; mLockM[i] = 0; pPolM[i] = 8'hFF; pSemM[i] = 0; pLockM[i] = 0;
    end
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R2 reset state of every word
    for (int i = 0; i < NM; i++) doRead("R2 master reset", {2'd0, 4'(i)}, 4'd0);
    for (int i = 0; i < NP; i++) doRead("R2 periph reset", {2'd1, 4'(i)}, 4'd0);
    // R7 idle outputs quiet
    @(negedge clk); #1 check("R7 idle", {30'd0, accGrant, accDeny}, 32'd0);

    // R1 reserved bits read as zero
    doWrite({2'd0, 4'd2}, 32'h7FFF_FFFF);
    doRead("R1 master format", {2'd0, 4'd2}, 4'd0);
    // R8 status follows regMaster
    doRead("R8 status m2", {2'd2, 4'd0}, 4'd2);
    doRead("R8 status m0", {2'd2, 4'd0}, 4'd0);

    // R4 domain 3 read only on periph 1
    doWrite({2'd1, 4'd1}, 32'h0000_00BF);
    doRead("R4 periph word", {2'd1, 4'd1}, 4'd0);
    doAcc("R4 write denied", 4'd2, 4'd1, 1'b1, 1'b0);
    doAcc("R4 read granted", 4'd2, 4'd1, 1'b0, 1'b0);
    doWrite({2'd1, 4'd4}, 32'h0000_0040);
    doAcc("R4 write only read", 4'd2, 4'd4, 1'b0, 1'b0);
    doAcc("R4 write only write", 4'd2, 4'd4, 1'b1, 1'b0);

    // R6 semaphore flag
    doWrite({2'd1, 4'd1}, 32'h4000_00BF);
    doAcc("R6 gate not held", 4'd2, 4'd1, 1'b0, 1'b0);
    doAcc("R6 gate held", 4'd2, 4'd1, 1'b0, 1'b1);
    doAcc("R6 gate held no policy", 4'd2, 4'd1, 1'b1, 1'b1);

    // R3 master lock
    doWrite({2'd0, 4'd2}, 32'h8000_0001);
    doWrite({2'd0, 4'd2}, 32'h0000_0002);
    doRead("R3 locked master", {2'd0, 4'd2}, 4'd0);
    doAcc("R3 locked domain used", 4'd2, 4'd0, 1'b0, 1'b0);

    // R5 peripheral lock
    doWrite({2'd1, 4'd3}, 32'h8000_0000);
    doWrite({2'd1, 4'd3}, 32'h0000_00FF);
    doRead("R5 locked periph", {2'd1, 4'd3}, 4'd0);
    doAcc("R5 locked policy", 4'd0, 4'd3, 1'b0, 1'b1);

    // R9 out-of-range indices
    doAcc("R9 master oob", 4'd7, 4'd0, 1'b0, 1'b1);
    doAcc("R9 periph oob", 4'd0, 4'd12, 1'b0, 1'b1);
    doWrite({2'd0, 4'd7}, 32'h0000_0003);
    doRead("R9 master oob read", {2'd0, 4'd7}, 4'd0);
    doRead("R9 master1 untouched", {2'd0, 4'd1}, 4'd0);
    doWrite({2'd1, 4'd11}, 32'h0000_0000);
    doRead("R9 periph oob read", {2'd1, 4'd11}, 4'd0);
    doRead("R9 status oob master", {2'd2, 4'd0}, 4'd9);

    // random phase
    for (int n = 0; n < 1500; n++) begin
      int op = $urandom % 3;
      logic [5:0] a = {2'($urandom % 3), 4'($urandom % 12)};
      if (op == 0) begin
        logic [31:0] d = $urandom;
        if ($urandom % 40 != 0) d[31] = 1'b0;
        doWrite(a, d);
      end else if (op == 1) begin
        doRead("R8 random read", a, 4'($urandom % 8));
      end else begin
        doAcc("R7 random access", 4'($urandom % 8), 4'($urandom % 12),
              1'($urandom), 1'($urandom));
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule